// File: doc/BRIEF.md
# Pipelined multiply-accumulate datapath

This block evaluates `a*b + c` on a continuous stream of unsigned operand triples and accepts a new triple on every clock. The work is split over three register stages. The first stage captures the two factors. The second stage forms their full-width product and captures the addend beside it. The third stage adds the two and holds the sum on the output.

A single valid flag enters with each triple and moves through the stages in step with its data, so a consumer sees exactly one qualified result per accepted triple, in issue order. There is no stall path: the stream never stops and is never throttled.

The parameter `C_LATE` selects when the addend is sampled. With `C_LATE=1` (the default), `c_i` is taken one cycle after its factors, at the moment the product is registered. With `C_LATE=0`, all three operands arrive together and the addend is delayed by one internal register.

Top module: `mac_pipe`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is low. Reset takes effect asynchronously and clears every stage's valid flag, so no result is qualified until new operands are issued after reset.
- R2: A triple with `valid_i` high at clock edge k produces `valid_o` high right after edge k+2, which is the third edge that counts the capturing edge.
- R3: When `valid_o` is high, `result_o` equals a*b + c for that triple. The factors are unsigned and `W` bits wide, and the result is `2W+1` bits wide, so the exact value never overflows (with W=8, 255*255+255 gives 65280).
- R4: With `C_LATE=1`, the addend of the triple issued at edge k is the value of `c_i` at edge k+1, and `c_i` at edge k is ignored. With `C_LATE=0`, the addend is the value of `c_i` at edge k.
- R5: Triples are accepted on consecutive edges without gaps. A burst of seven triples issued at edges 1 to 7 delivers all seven results by edge 9.
- R6: `valid_o` is high only for cycles that carry an issued triple. Idle input cycles appear as idle output cycles in the same positions, and results leave in issue order.
- R7: While `valid_o` is low, `result_o` keeps the last qualified result unchanged, whatever is applied on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `a_i`/`b_i` (and `c_i` when `C_LATE=0`) this cycle |
| a_i | input | W | First factor, unsigned |
| b_i | input | W | Second factor, unsigned |
| c_i | input | W | Addend, unsigned; timing set by `C_LATE` |
| valid_o | output | 1 | Qualifies `result_o` |
| result_o | output | 2W+1 | Sum a*b + c |

## Verification
On every cycle, the bound checker enforces the three-edge latency of the valid flag, the arithmetic value of each qualified result from the port history (including the addend offset chosen by `C_LATE`), the idle output during reset, and the holding of the output between results. Other properties only appear in the bench's scenarios: a full seven-item burst draining by edge 9, a reset that arrives while items are in flight and leaves no stale result, all-ones operands at the width limit, and two instances with different `C_LATE` values run side by side on the same stream.

// File: rtl/mac_pipe_pkg.sv
package mac_pipe_pkg;

  function automatic int unsigned prod_width(input int unsigned w);
    return 2 * w;
  endfunction

  // one extra bit absorbs the carry of product + addend
  function automatic int unsigned res_width(input int unsigned w);
    return 2 * w + 1;
  endfunction

endpackage

// File: rtl/mac_pipe_opnd.sv
module mac_pipe_opnd #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);

  logic         vld_q;
  logic [W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign valid_o = vld_q;
  assign a_o     = a_q;
  assign b_o     = b_q;

endmodule

// File: rtl/mac_pipe_mul.sv
module mac_pipe_mul
  import mac_pipe_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = prod_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  output logic          valid_o,
  output logic [PW-1:0] prod_o,
  output logic [W-1:0]  c_o
);

  logic          vld_q;
  logic [PW-1:0] prod_q;
  logic [W-1:0]  c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      prod_q <= PW'(a_i) * PW'(b_i);
      c_q    <= c_i;
    end
  end

  assign valid_o = vld_q;
  assign prod_o  = prod_q;
  assign c_o     = c_q;

endmodule

// File: rtl/mac_pipe_add.sv
module mac_pipe_add
  import mac_pipe_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned PW = prod_width(W),
  localparam int unsigned RW = res_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [PW-1:0] prod_i,
  input  logic [W-1:0]  c_i,
  output logic          valid_o,
  output logic [RW-1:0] sum_o
);

  logic          vld_q;
  logic [RW-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= valid_i;
  end

  // load only for real items so the output holds between results
  always_ff @(posedge clk_i) begin
    if (valid_i) sum_q <= RW'(prod_i) + RW'(c_i);
  end

  assign valid_o = vld_q;
  assign sum_o   = sum_q;

endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pipe_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter bit          C_LATE = 1'b1,
  localparam int unsigned PW    = prod_width(W),
  localparam int unsigned RW    = res_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  output logic          valid_o,
  output logic [RW-1:0] result_o
);

  logic          s1_vld, s2_vld;
  logic [W-1:0]  s1_a, s1_b;
  logic [W-1:0]  s2_c_in, s2_c;
  logic [PW-1:0] s2_prod;

  mac_pipe_opnd #(.W(W)) u_opnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (s1_vld),
    .a_o     (s1_a),
    .b_o     (s1_b)
  );

  generate
    if (C_LATE) begin : g_c_late
      // addend arrives with the product stage, no local storage
      assign s2_c_in = c_i;
    end else begin : g_c_aligned
      logic [W-1:0] c_dly_q;
      always_ff @(posedge clk_i) begin
        if (valid_i) c_dly_q <= c_i;
      end
      assign s2_c_in = c_dly_q;
    end
  endgenerate

  mac_pipe_mul #(.W(W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_vld),
    .a_i     (s1_a),
    .b_i     (s1_b),
    .c_i     (s2_c_in),
    .valid_o (s2_vld),
    .prod_o  (s2_prod),
    .c_o     (s2_c)
  );

  mac_pipe_add #(.W(W)) u_add (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s2_vld),
    .prod_i  (s2_prod),
    .c_i     (s2_c),
    .valid_o (valid_o),
    .sum_o   (result_o)
  );

endmodule

// File: rtl/mac_pipe_chk.sv
module mac_pipe_chk
  import mac_pipe_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter bit          C_LATE = 1'b1,
  localparam int unsigned RW    = res_width(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic [W-1:0]  c_i,
  input logic          valid_o,
  input logic [RW-1:0] result_o
);

  logic [1:0] live_cnt;  // edges seen since reset release, saturating at 3
  logic       seen_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_cnt <= '0;
      seen_res <= 1'b0;
    end else begin
      if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
      if (valid_o) seen_res <= 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_idle_in_reset: assert (!valid_o);
    end
  end

  a_r2_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cnt == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  generate
    if (C_LATE) begin : g_late
      a_r3_r4_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_cnt == 2'd3 && valid_o) |->
          (result_o == RW'($past(a_i, 3)) * RW'($past(b_i, 3)) + RW'($past(c_i, 2))));
    end else begin : g_aligned
      a_r3_r4_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_cnt == 2'd3 && valid_o) |->
          (result_o == RW'($past(a_i, 3)) * RW'($past(b_i, 3)) + RW'($past(c_i, 3))));
    end
  endgenerate

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_res && !valid_o) |-> $stable(result_o));

endmodule

bind mac_pipe mac_pipe_chk #(.W(W), .C_LATE(C_LATE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .c_i      (c_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/mac_pipe_tb.sv
module mac_pipe_tb;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int RW    = 2 * W + 1;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, c_lt = '0, c_al = '0;
  logic vo_lt, vo_al;
  logic [RW-1:0] r_lt, r_al;

  always #(CLK_P / 2) clk = ~clk;

  mac_pipe #(.W(W), .C_LATE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .c_i(c_lt), .valid_o(vo_lt), .result_o(r_lt));

  mac_pipe #(.W(W), .C_LATE(1'b0)) u_dut_aligned (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .c_i(c_al), .valid_o(vo_al), .result_o(r_al));

  int checks = 0, errors = 0, cyc = 0, outs_lt = 0;
  bit done = 1'b0;
  bit va [DEPTH];
  logic [W-1:0] aa [DEPTH], ba [DEPTH], ca [DEPTH];
  logic [RW-1:0] last_lt, last_al;
  bit seen_lt = 1'b0, seen_al = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_one(input bit vo, input logic [RW-1:0] r, input string rq,
                           inout logic [RW-1:0] last, inout bit seen);
    bit ev;
    logic [RW-1:0] er;
    ev = (cyc > 2) ? va[cyc-2] : 1'b0;
    chk(vo === ev, ev ? "R2" : "R6", longint'(vo), longint'(ev));
    if (ev) begin
      er = RW'(aa[cyc-2]) * RW'(ba[cyc-2]) + RW'(ca[cyc-2]);
      chk(r === er, rq, longint'(r), longint'(er));
      last = er;
      seen = 1'b1;
    end else if (seen) begin
      chk(r === last, "R7", longint'(r), longint'(last));
    end
  endtask

  // one clock: drive inputs for the next edge, then check after it
  task automatic tick(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] c);
    cyc++;
    va[cyc] = v; aa[cyc] = a; ba[cyc] = b; ca[cyc] = c;
    valid_i = v;
    a_i  = v ? a : W'($urandom);
    b_i  = v ? b : W'($urandom);
    c_al = v ? c : W'($urandom);
    c_lt = va[cyc-1] ? ca[cyc-1] : W'($urandom);  // R4: addend one cycle late
    @(posedge clk);
    @(negedge clk);
    if (vo_lt) outs_lt++;
    check_one(vo_lt, r_lt, "R3/R4 late", last_lt, seen_lt);
    check_one(vo_al, r_al, "R3/R4 aligned", last_al, seen_al);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk(!vo_lt && !vo_al, "R1", longint'({vo_lt, vo_al}), 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) va[i] = 1'b0;
    cyc = 0; outs_lt = 0; seen_lt = 1'b0; seen_al = 1'b0;
    valid_i = 1'b0;
    rst_ni = 1'b1;
    chk(!vo_lt && !vo_al, "R1", longint'({vo_lt, vo_al}), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) va[i] = 1'b0;
    @(negedge clk);
    chk(!vo_lt && !vo_al, "R1", longint'({vo_lt, vo_al}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R5: seven back-to-back triples, all out by edge 9
    for (int i = 1; i <= 7; i++) tick(1'b1, W'(i), W'(i + 10), W'(3 * i));
    tick(1'b0, '0, '0, '0);
    tick(1'b0, '0, '0, '0);
    chk(outs_lt == 7, "R5", outs_lt, 7);
    // R6: alternating bubbles
    for (int i = 0; i < 12; i++) tick(i[0], W'(i * 7), W'(i + 1), W'(200 - i));
    // R3: width limits
    tick(1'b1, '1, '1, '1);
    tick(1'b1, '0, '0, '0);
    tick(1'b1, '1, '1, '0);
    tick(1'b1, '0, '1, '1);
    // R7: long idle with changing inputs
    for (int i = 0; i < 6; i++) tick(1'b0, '0, '0, '0);
    // random stream
    for (int i = 0; i < 300; i++)
      tick(($urandom % 4) != 0, W'($urandom), W'($urandom), W'($urandom));
    // R1: reset with items in flight
    tick(1'b1, 8'd9, 8'd9, 8'd9);
    tick(1'b1, 8'd5, 8'd4, 8'd3);
    do_reset();
    for (int i = 0; i < 4; i++) tick(1'b0, '0, '0, '0);
    for (int i = 0; i < 20; i++) tick(1'b1, W'($urandom), W'($urandom), W'($urandom));
    tick(1'b0, '0, '0, '0);
    tick(1'b0, '0, '0, '0);
    tick(1'b0, '0, '0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule